// File: doc/BRIEF.md
# Serial Flash Read-Array Responder

This block plays the memory side of a serial flash read transfer. A host pulls chip select low and shifts in a one-byte command and a 24-bit start address. It then waits a command-dependent number of filler bytes, and after that it receives an unbroken stream of bytes from an internal byte array. The block keeps its own byte pointer. That pointer steps after every byte and rolls over from the top of the array to address zero with no pause. Releasing chip select ends the transfer at any point, even in the middle of a byte.

The serial clock, chip select and serial input pins are sampled in the system clock domain through a synchronizer. Edges of the serial clock are detected there. All state, including the serial output bit and its drive-enable flag, is registered on the system clock, and the array is a block-RAM style memory with a registered read. The serial clock must stay at least six system clocks high and six low. The array is filled through a separate synchronous write port that only the testbench uses.

The array holds 2^`ADDR_W` bytes. The low `ADDR_W` bits of the 24-bit address pick the start byte, and a full-size device uses `ADDR_W` = 21.

Top module: `spi_flash_rd`

## Requirements
- R1: While chip select is low, the command byte is taken MSB first on rising serial-clock edges. The values 0x03, 0x0B and 0x1B start a read.
- R2: Three address bytes follow the command, MSB first. Bits [ADDR_W-1:0] of the resulting 24-bit value select the first byte read, and the higher bits have no effect.
- R3: The number of filler bytes after the address is zero for 0x03, one for 0x0B and two for 0x1B. The output enable stays low during the command, address and filler bytes. The first data bit is driven on the falling edge that follows the last address or filler bit.
- R4: Data leaves MSB first. The serial output bit changes only on falling serial-clock edges.
- R5: Continued clocking returns consecutive bytes, and the output enable stays high throughout the data phase.
- R6: After byte 2^ADDR_W-1 the stream continues with byte 0, with no gap bit.
- R7: Raising chip select at any time, including part-way through a byte, drops the output enable within four system clocks. The next command then starts from a clean command phase.
- R8: Any other command value is ignored. The output enable stays low until chip select is raised and lowered again.
- R9: After a synchronous reset, the output enable and the serial output bit are both 0.
- R10: A write-port strobe stores `load_data` at `load_addr`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host (idles low) |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data bit to host |
| miso_oe | output | 1 | High while the block drives `miso` |
| load_we | input | 1 | Array write strobe |
| load_addr | input | ADDR_W | Array write address |
| load_data | input | 8 | Array write data |

## Verification
Two events can land in the same system-clock cycle. One is the release of chip select and the other is a falling serial-clock edge that would shift the next data bit. The bench raises chip select and lowers the serial clock at the same instant, three bits into a byte. It then judges that the output enable drops, and that a fresh 0x03 read right afterwards returns exactly the expected bytes. The other case is the pointer rolling over on the same edge that launches a new byte. Reads with each command, started just below the array top, must show the last bytes and then byte 0 with no extra bit.

// File: rtl/spi_flash_rd_pkg.sv
package spi_flash_rd_pkg;

  localparam logic [7:0] OP_RD_SLOW = 8'h03;
  localparam logic [7:0] OP_RD_FAST = 8'h0B;
  localparam logic [7:0] OP_RD_MAX  = 8'h1B;

  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 24;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic       valid;
    logic [1:0] fill_bytes;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    case (op)
      OP_RD_SLOW: r = '{valid: 1'b1, fill_bytes: 2'd0};
      OP_RD_FAST: r = '{valid: 1'b1, fill_bytes: 2'd1};
      OP_RD_MAX:  r = '{valid: 1'b1, fill_bytes: 2'd2};
      default:    r = '{valid: 1'b0, fill_bytes: 2'd0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_flash_rd_sync.sv
module spi_flash_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  // bit order per stage: {sck, cs_n, mosi}
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] pipe [STAGES];
  logic       sck_d;
  logic [2:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE_VAL;
      sck_d <= 1'b0;
    end else begin
      pipe[0] <= {sck_in, cs_n_in, mosi_in};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_d <= pipe[STAGES-1][2];
    end
  end

  assign last     = pipe[STAGES-1];
  assign sck_rise = last[2] & ~sck_d;
  assign sck_fall = ~last[2] & sck_d;
  assign cs_act   = ~last[1];
  assign mosi_s   = last[0];

endmodule

// File: rtl/spi_flash_rd_mem.sv
module spi_flash_rd_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_flash_rd_ctrl.sv
module spi_flash_rd_ctrl
  import spi_flash_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  output phase_t            phase,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              data_fall,
  output logic              byte_start
);
  localparam int CNT_W = $clog2(ADDR_BITS);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       op_sr;
  logic [7:0]       op_next;
  logic [1:0]       fill_n;
  logic [2:0]       dbit;
  op_info_t         info;
  logic [CNT_W-1:0] fill_last;

  always_comb begin
    op_next   = {op_sr[6:0], mosi_s};
    info      = decode_op(op_next);
    fill_last = CNT_W'({fill_n - 2'd1, 3'b111});
  end

  assign data_fall  = cs_act & sck_fall & (phase == PH_DATA);
  assign byte_start = data_fall & (dbit == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      op_sr   <= '0;
      fill_n  <= '0;
      dbit    <= '0;
      rd_addr <= '0;
    end else if (!cs_act) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      op_sr  <= '0;
      fill_n <= '0;
      dbit   <= '0;
    end else if (sck_rise) begin
      case (phase)
        PH_CMD: begin
          op_sr <= op_next;
          if (cnt == CNT_W'(CMD_BITS - 1)) begin
            cnt    <= '0;
            fill_n <= info.fill_bytes;
            phase  <= info.valid ? PH_ADDR : PH_IGNORE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          rd_addr <= {rd_addr[ADDR_W-2:0], mosi_s};
          if (cnt == CNT_W'(ADDR_BITS - 1)) begin
            cnt   <= '0;
            phase <= (fill_n == 2'd0) ? PH_DATA : PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == fill_last) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (data_fall) begin
      dbit <= dbit + 1'b1;
      if (byte_start) rd_addr <= rd_addr + 1'b1;
    end
  end

endmodule

// File: rtl/spi_flash_rd_tx.sv
module spi_flash_rd_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              data_fall,
  input  logic              byte_start,
  input  logic [DATA_W-1:0] din,
  output logic              miso,
  output logic              miso_oe
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sr      <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (data_fall) begin
      miso_oe <= 1'b1;
      if (byte_start) begin
        miso <= din[DATA_W-1];
        sr   <= {din[DATA_W-2:0], 1'b0};
      end else begin
        miso <= sr[DATA_W-1];
        sr   <= {sr[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_flash_rd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_data
);
  logic              sck_rise;
  logic              sck_fall;
  logic              cs_act;
  logic              mosi_s;
  phase_t            phase;
  logic [ADDR_W-1:0] rd_addr;
  logic              data_fall;
  logic              byte_start;
  logic [7:0]        rd_byte;

  spi_flash_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_in   (sck),
    .cs_n_in  (cs_n),
    .mosi_in  (mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .mosi_s   (mosi_s)
  );

  spi_flash_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .mosi_s     (mosi_s),
    .phase      (phase),
    .rd_addr    (rd_addr),
    .data_fall  (data_fall),
    .byte_start (byte_start)
  );

  spi_flash_rd_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (rd_addr),
    .rdata (rd_byte)
  );

  spi_flash_rd_tx #(.DATA_W(8)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .data_fall  (data_fall),
    .byte_start (byte_start),
    .din        (rd_byte),
    .miso       (miso),
    .miso_oe    (miso_oe)
  );

endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk
  import spi_flash_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              data_fall,
  input logic              byte_start,
  input logic [ADDR_W-1:0] rd_addr,
  input phase_t            phase,
  input logic              miso,
  input logic              miso_oe
);

  AST_OE_DROP_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe); // R7

  AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (phase == PH_DATA)); // R3

  AST_IGNORED_OP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> !miso_oe); // R8

  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    byte_start |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R6

  AST_MISO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !data_fall) |=> $stable(miso)); // R4

endmodule

bind spi_flash_rd spi_flash_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_act     (cs_act),
  .data_fall  (data_fall),
  .byte_start (byte_start),
  .rd_addr    (rd_addr),
  .phase      (phase),
  .miso       (miso),
  .miso_oe    (miso_oe)
);

// File: tb/spi_flash_rd_tb.sv
module spi_flash_rd_tb;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sck = 1'b0;
  logic              cs_n = 1'b1;
  logic              mosi = 1'b0;
  logic              miso;
  logic              miso_oe;
  logic              load_we = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [7:0]        load_data = '0;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_flash_rd #(.ADDR_W(ADDR_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    load_we   = 1'b1;
    load_addr = ADDR_W'(a);
    load_data = d;
    model[a]  = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  // one byte: drive on low half, sample before rise, recheck before fall
  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                          output bit oe_all, output bit oe_any, output bit stab);
    oe_all = 1'b1; oe_any = 1'b0; stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i]  = miso;
      oe_all = oe_all & miso_oe;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== rx[i]) stab = 1'b0;
      sck = 1'b0;
    end
  endtask

  task automatic start_cmd(input logic [7:0] op, input logic [23:0] addr, input int nfill,
                           output bit hdr_oe);
    logic [7:0] rx;
    bit a, b, s;
    hdr_oe = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    spi_byte(op, rx, a, b, s);              hdr_oe |= b;
    spi_byte(addr[23:16], rx, a, b, s);     hdr_oe |= b;
    spi_byte(addr[15:8], rx, a, b, s);      hdr_oe |= b;
    spi_byte(addr[7:0], rx, a, b, s);       hdr_oe |= b;
    for (int k = 0; k < nfill; k++) begin
      spi_byte(8'h00, rx, a, b, s);         hdr_oe |= b;
    end
  endtask

  task automatic end_cmd(input string tag);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(miso_oe == 1'b0, tag, miso_oe, 0);
  endtask

  task automatic read_check(input logic [7:0] op, input logic [23:0] addr, input int nfill,
                            input int nbytes, input string tag);
    logic [7:0] rx;
    bit oe_all, oe_any, stab, hdr_oe;
    start_cmd(op, addr, nfill, hdr_oe);
    check(!hdr_oe, {"R3 oe low before data ", tag}, hdr_oe, 0);
    for (int i = 0; i < nbytes; i++) begin
      int a = (int'(addr) + i) % DEPTH;
      spi_byte(8'hA5, rx, oe_all, oe_any, stab);
      check(rx == model[a], {"R1 R5 data ", tag}, rx, model[a]);
      check(oe_all, {"R5 oe held ", tag}, oe_all, 1);
      check(stab, {"R4 bit stable ", tag}, stab, 1);
    end
    end_cmd({"R7 release ", tag});
  endtask

  task automatic t_reset();
    check(miso_oe == 1'b0, "R9 oe after reset", miso_oe, 0);
    check(miso == 1'b0, "R9 miso after reset", miso, 0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < DEPTH; a++)
      load_byte(a, 8'((a * 37 + 11) ^ (a >> 2)));
  endtask

  task automatic t_wrap_each_op();
    read_check(8'h03, 24'(DEPTH - 2), 0, 4, "R6 R3 op03 wrap");
    read_check(8'h0B, 24'(DEPTH - 1), 1, 3, "R6 R3 op0B wrap");
    read_check(8'h1B, 24'(DEPTH - 3), 2, 5, "R6 R3 op1B wrap");
  endtask

  task automatic t_high_addr();
    read_check(8'h03, 24'hABC155, 0, 2, "R2 upper bits ignored");
  endtask

  task automatic t_bad_op();
    logic [7:0] rx;
    bit a, any, s, hdr;
    start_cmd(8'h9F, 24'h000010, 0, hdr);
    check(!hdr, "R8 header silent", hdr, 0);
    for (int k = 0; k < 3; k++) begin
      spi_byte(8'h03, rx, a, any, s);
      check(!any, "R8 oe stays low", any, 0);
    end
    end_cmd("R8 release");
    read_check(8'h0B, 24'h000040, 1, 2, "R8 recovery");
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    bit a, b, s, hdr;
    start_cmd(8'h0B, 24'h000010, 1, hdr);
    spi_byte(8'h00, rx, a, b, s);
    check(rx == model[16], "R7 byte before abort", rx, model[16]);
    for (int i = 0; i < 3; i++) begin
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 2) sck = 1'b0;
    end
    // release select on the same instant as the falling clock edge
    sck  = 1'b0;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miso_oe == 1'b0, "R7 oe off after mid-byte abort", miso_oe, 0);
    read_check(8'h03, 24'h000020, 0, 2, "R7 restart");
  endtask

  task automatic t_load();
    load_byte(5, 8'h3C);
    load_byte(6, 8'hC3);
    read_check(8'h03, 24'h000004, 0, 3, "R10 reloaded");
    check(model[5] == 8'h3C, "R10 model", model[5], 8'h3C);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_preload();
    t_wrap_each_op();
    t_high_addr();
    t_bad_op();
    t_abort();
    t_load();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule